// File: doc/BRIEF.md
# Strobed Configuration Link Target

This block is the receiving end of a narrow parallel configuration link. A host drives one 8-bit port. The top bit is a strobe, and the lower seven bits carry either a register address or a data value. The target takes the 7-bit field on each rising edge of the strobe. It uses the value range of the field to tell the two phases apart. A field from 0x40 to 0x7f selects one of 64 six-bit registers. A field from 0x00 to 0x3f is data, and it is stored into the register selected last.

The selected register is always shown on a 7-bit readback output, so a host reads a register by sending only an address phase. Four of the registers describe a connection in a routing table:

- Registers 0 and 1 hold the upper and lower six bits of a 12-bit destination index.
- Registers 2 and 3 hold the same halves of a 12-bit source index.

Writing register 3 stores the connection into the table. A separate lookup port returns the source that any destination currently uses.

Top module: `cfg_link_target`

## Requirements
- R1: After reset the readback is 0, every register holds 0, no register is selected, and every destination in the routing table selects source 0.
- R2: The 7-bit field is taken only on a 0-to-1 transition of port bit 7. Holding bit 7 high while the field changes takes nothing further.
- R3: A field value from 0x40 to 0x7f selects register number field[5:0]. The readback then shows that register's contents.
- R4: A field value from 0x00 to 0x3f writes field[5:0] into the selected register. Further data phases without a new address keep writing the same register.
- R5: The readback is the 6-bit register value with a zero in bit 6, so a register holding 0x3f reads as 0x3f.
- R6: A data phase that arrives before any address phase since reset changes no register.
- R7: A write to register 3 stores a routing entry. The destination is {reg0, reg1}, and the source is {reg2, the value written to register 3}.
- R8: Each destination holds exactly one source. Storing a new entry for a destination replaces only that destination, and one source may be stored for many destinations.
- R9: A routing entry whose destination index is NUM_DST or larger is discarded, and no table entry changes.
- R10: Changes of the field while bit 7 stays low have no effect.
- R11: The lookup output gives the source of the destination on the lookup input one clock later. The readback follows a selection or a write within two clocks of the strobe being sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_in | input | 8 | Bit 7 is the strobe; bits 6:0 carry an address or data field |
| rb_val | output | 7 | Contents of the selected register, zero-extended |
| lkp_dst | input | 4 | Destination index to look up in the routing table |
| lkp_src | output | 12 | Source index stored for lkp_dst |

## Verification
Some properties are checked on every cycle. A strobe edge is a single-cycle pulse. The selected address moves only on a captured strobe. No register is written before an address has been taken. Only register 3 can store a table entry, and an entry with an out-of-range destination never reaches the table.

Other behaviour is shown only by the bench scenarios:

- the value-range split between address and data;
- repeated data writes to one register;
- ignoring a field that changes while the strobe is held high;
- aliasing of out-of-range destinations onto entry 0;
- fan-out of one source to many destinations.

// File: rtl/cfg_link_pkg.sv
package cfg_link_pkg;
  localparam int LINK_W  = 8;
  localparam int FIELD_W = LINK_W - 1;
  localparam int REG_W   = 6;
  localparam int NREG    = 64;
  localparam int IDX_W   = 2 * REG_W;
  // indices of the registers that form a routing entry
  localparam int RT_DST_HI = 0;
  localparam int RT_DST_LO = 1;
  localparam int RT_SRC_HI = 2;
  localparam int RT_SRC_LO = 3;
endpackage

// File: rtl/cfg_link_strobe.sv
module cfg_link_strobe #(
  parameter int LINK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINK_W-1:0] link_i,
  output logic              ev_o,
  output logic [LINK_W-2:0] field_o
);
  logic [LINK_W-1:0] smp_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= link_i;
      prev_q <= smp_q[LINK_W-1];
    end
  end

  assign ev_o    = smp_q[LINK_W-1] & ~prev_q;
  assign field_o = smp_q[LINK_W-2:0];

  // R2: a capture is a single-cycle pulse per strobe rise
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ev_o |=> !ev_o);
endmodule

// File: rtl/cfg_link_decode.sv
module cfg_link_decode #(
  parameter int FIELD_W = 7,
  parameter int REG_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [REG_W-1:0]   sel_o,
  output logic               sel_vld_o,
  output logic               we_o,
  output logic [REG_W-1:0]   wdata_o
);
  logic [REG_W-1:0] sel_q;
  logic             vld_q;
  logic             is_addr;

  assign is_addr = field_i[FIELD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      vld_q <= 1'b0;
    end else if (ev_i && is_addr) begin
      sel_q <= field_i[REG_W-1:0];
      vld_q <= 1'b1;
    end
  end

  assign we_o      = ev_i & ~is_addr & vld_q;
  assign wdata_o   = field_i[REG_W-1:0];
  assign sel_o     = sel_q;
  assign sel_vld_o = vld_q;

  // R10: the selection moves only on a captured strobe
  a_r10_sel_quiet: assert property (@(posedge clk) disable iff (rst)
    !ev_i |=> $stable(sel_q));
endmodule

// File: rtl/cfg_link_bank.sv
module cfg_link_bank #(
  parameter int REG_W = 6,
  parameter int NREG  = 64,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [AW-1:0]    sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W:0]   rb_o,
  output logic [REG_W-1:0] r0_o,
  output logic [REG_W-1:0] r1_o,
  output logic [REG_W-1:0] r2_o
);
  logic [REG_W-1:0] mem [NREG];
  logic [REG_W:0]   rb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      rb_q <= '0;
    end else begin
      if (we_i) mem[sel_i] <= wdata_i;
      rb_q <= {1'b0, mem[sel_i]};
    end
  end

  assign rb_o = rb_q;
  assign r0_o = mem[0];
  assign r1_o = mem[1];
  assign r2_o = mem[2];
endmodule

// File: rtl/cfg_link_route.sv
module cfg_link_route #(
  parameter int IDX_W   = 12,
  parameter int NUM_DST = 16,
  localparam int DW     = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic [DW-1:0]    lkp_dst_i,
  output logic [IDX_W-1:0] lkp_src_o
);
  localparam logic [IDX_W:0] DST_LIM = NUM_DST[IDX_W:0];

  logic [IDX_W-1:0] tbl [NUM_DST];
  logic             in_range;
  logic [IDX_W-1:0] lkp_q;

  assign in_range = ({1'b0, dst_i} < DST_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_DST; i++) tbl[i] <= '0;
      lkp_q <= '0;
    end else begin
      if (commit_i && in_range) tbl[dst_i[DW-1:0]] <= src_i;
      lkp_q <= tbl[lkp_dst_i];
    end
  end

  assign lkp_src_o = lkp_q;

  // R9: an out-of-range destination leaves entry 0 untouched
  a_r9_oob_drop: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !in_range) |=> $stable(tbl[0]));
endmodule

// File: rtl/cfg_link_target.sv
module cfg_link_target #(
  parameter int LINK_W  = cfg_link_pkg::LINK_W,
  parameter int REG_W   = cfg_link_pkg::REG_W,
  parameter int NREG    = cfg_link_pkg::NREG,
  parameter int NUM_DST = 16,
  localparam int FIELD_W = LINK_W - 1,
  localparam int IDX_W   = 2 * REG_W,
  localparam int AW      = $clog2(NREG),
  localparam int DW      = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINK_W-1:0] link_in,
  output logic [REG_W:0]    rb_val,
  input  logic [DW-1:0]     lkp_dst,
  output logic [IDX_W-1:0]  lkp_src
);
  import cfg_link_pkg::*;

  logic               ev;
  logic [FIELD_W-1:0] field;
  logic [REG_W-1:0]   sel;
  logic               sel_vld;
  logic               we;
  logic [REG_W-1:0]   wdata;
  logic [REG_W-1:0]   r0, r1, r2;
  logic               commit;

  cfg_link_strobe #(.LINK_W(LINK_W)) u_strobe (
    .clk(clk), .rst(rst), .link_i(link_in), .ev_o(ev), .field_o(field));

  cfg_link_decode #(.FIELD_W(FIELD_W), .REG_W(REG_W)) u_dec (
    .clk(clk), .rst(rst), .ev_i(ev), .field_i(field),
    .sel_o(sel), .sel_vld_o(sel_vld), .we_o(we), .wdata_o(wdata));

  cfg_link_bank #(.REG_W(REG_W), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .we_i(we), .sel_i(sel[AW-1:0]), .wdata_i(wdata),
    .rb_o(rb_val), .r0_o(r0), .r1_o(r1), .r2_o(r2));

  assign commit = we && (sel == REG_W'(RT_SRC_LO));

  cfg_link_route #(.IDX_W(IDX_W), .NUM_DST(NUM_DST)) u_route (
    .clk(clk), .rst(rst), .commit_i(commit),
    .dst_i({r0, r1}), .src_i({r2, wdata}),
    .lkp_dst_i(lkp_dst), .lkp_src_o(lkp_src));

  // R6: no register write before an address phase
  a_r6_addr_first: assert property (@(posedge clk) disable iff (rst)
    we |-> sel_vld);
  // R7: only register 3 stores a routing entry
  a_r7_commit_reg3: assert property (@(posedge clk) disable iff (rst)
    commit |-> (ev && sel == REG_W'(RT_SRC_LO)));
  // R4: writes happen only on a captured data phase
  a_r4_write_on_strobe: assert property (@(posedge clk) disable iff (rst)
    we |-> ev);
endmodule

// File: tb/cfg_link_target_test.sv
module cfg_link_target_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  link_in = '0;
  logic [6:0]  rb_val;
  logic [3:0]  lkp_dst = '0;
  logic [11:0] lkp_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_route;
    logic [11:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  event  mon_ev;

  always #10 clk = ~clk;

  cfg_link_target uut (.clk(clk), .rst(rst), .link_in(link_in),
    .rb_val(rb_val), .lkp_dst(lkp_dst), .lkp_src(lkp_src));

  // monitor: pops expected items and compares with the outputs
  always @(mon_ev) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [11:0] act;
      it = sbq.pop_front();
      act = it.is_route ? lkp_src : {5'b0, rb_val};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic send(input logic [6:0] f);
    @(negedge clk) link_in = {1'b0, f};
    repeat (2) @(negedge clk);
    link_in = {1'b1, f};
    repeat (2) @(negedge clk);
    link_in = {1'b0, f};
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [5:0] d);
    send({1'b1, a});
    send({1'b0, d});
  endtask

  task automatic exp_rb(input logic [6:0] e, input string tag);
    @(negedge clk);
    sbq.push_back('{1'b0, {5'b0, e}, tag});
    -> mon_ev;
    #1;
  endtask

  task automatic exp_rt(input logic [3:0] d, input logic [11:0] e, input string tag);
    @(negedge clk) lkp_dst = d;
    repeat (2) @(negedge clk);
    sbq.push_back('{1'b1, e, tag});
    -> mon_ev;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_rb(7'h00, "R1 readback after reset");
    exp_rt(4'd7, 12'h000, "R1 route reset");
    // R6: data before any address
    send(7'h2a);
    send(7'h40);
    exp_rb(7'h00, "R6 early data ignored");
    // R3/R4: select and write
    wr(6'd5, 6'h11);
    exp_rb(7'h11, "R4 write reg5");
    send(7'h22);
    exp_rb(7'h22, "R4 repeated data same reg");
    wr(6'd63, 6'h3f);
    exp_rb(7'h3f, "R5 max value zero-extended");
    send(7'h45);
    exp_rb(7'h22, "R3 reselect reg5");
    // R10: field wiggles with strobe low
    @(negedge clk) link_in = 8'h33;
    repeat (4) @(negedge clk) link_in = link_in + 8'h01;
    repeat (3) @(negedge clk);
    exp_rb(7'h22, "R10 field moves while strobe low");
    // R2: field changes while strobe held high
    @(negedge clk) link_in = 8'h47;
    repeat (2) @(negedge clk);
    link_in = 8'hc7;
    repeat (3) @(negedge clk);
    link_in = 8'h95;
    repeat (3) @(negedge clk);
    link_in = 8'h15;
    repeat (3) @(negedge clk);
    exp_rb(7'h00, "R2 no capture while held high");
    send(7'h3e);
    exp_rb(7'h3e, "R11 readback follows write");
    // R7: route dst 5 <- src 0x123
    wr(6'd0, 6'h00); wr(6'd1, 6'h05); wr(6'd2, 6'h04); wr(6'd3, 6'h23);
    exp_rt(4'd5, 12'h123, "R7 commit dst5");
    // R8: same source fans out to dst 9
    wr(6'd1, 6'h09);
    wr(6'd3, 6'h23);
    exp_rt(4'd9, 12'h123, "R8 fan-out dst9");
    exp_rt(4'd5, 12'h123, "R8 dst5 kept");
    wr(6'd1, 6'h05);
    wr(6'd2, 6'h00);
    wr(6'd3, 6'h0b);
    exp_rt(4'd5, 12'h00b, "R8 dst5 replaced");
    exp_rt(4'd9, 12'h123, "R8 dst9 untouched");
    // R9: destination 64 aliases entry 0 if not dropped
    wr(6'd0, 6'h01); wr(6'd1, 6'h00); wr(6'd2, 6'h3f); wr(6'd3, 6'h3f);
    exp_rt(4'd0, 12'h000, "R9 out-of-range dropped");
    send(7'h42);
    exp_rb(7'h3f, "R3 read reg2");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule